// File: doc/BRIEF.md
# Strobe-Addressed Static Memory Read Port

This block is a small static memory with a strobe-driven access interface, modelled on a single internal clock. The active-low strobe `strobe_n` is sampled every clock. Its falling transition starts an access. The address and the secondary select `sel_lat_n` are captured at that point and held for the whole access. The primary select `sel_live_n` is never captured and always acts directly.

While the strobe is low with both selects active:
- A high `wr_n` reads the captured location. The output is enabled at once, and the data becomes valid one clock later.
- A low `wr_n` writes `din` into the captured location, and the output stays disabled.

When the strobe rises, the output data is frozen until the next falling transition. From then on, the live value of the secondary select gates the output together with the primary select. High impedance is represented by `dout_oe` going low. `dout_valid` tells an enabled-but-undefined output apart from one that shows real data.

Because the secondary select is captured with the address, it acts as one extra high-order address bit. Two such blocks can share an address bus and be told apart by that bit alone.

Top module: `strobe_sram`

## Requirements
- R1: On a clock where `strobe_n` is sampled low after having been sampled high (falling transition), `addr` and `sel_lat_n` are captured. A read or write in that access uses the captured values.
- R2: While `strobe_n` stays low after the capture, changes on `addr` and `sel_lat_n` have no effect on the access in progress, its output data or its write location.
- R3: While `strobe_n` is low, `dout_oe` is 1 exactly when `sel_live_n` is 0, `wr_n` is 1 and the captured `sel_lat_n` is 0. Once valid, `dout` equals the word stored at the captured address.
- R4: From the clock that samples `strobe_n` high after a low phase until the next falling transition, `dout` keeps its last value, whatever `addr` or `wr_n` do.
- R5: While `strobe_n` is high, the live `sel_lat_n` gates the output: with `sel_lat_n` at 1, `dout_oe` is 0.
- R6: Whenever `sel_live_n` is 1, `dout_oe` is 0.
- R7: In the first clock after the falling transition, `dout_valid` is 0 even if `dout_oe` is 1. From the next clock of a read, `dout_valid` is 1.
- R8: An access started with `sel_lat_n` captured at 1 neither reads nor writes. The output stays disabled and memory is unchanged, even if the live `sel_lat_n` later goes to 0.
- R9: With `strobe_n` low, `sel_live_n` 0, captured `sel_lat_n` 0 and `wr_n` 0, each clock stores `din` at the captured address, and `dout_oe` stays 0.
- R10: After a synchronous reset with `rst_n` at 0, `dout_valid` is 0. With both selects at 1, `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n | input | 1 | Active-low access strobe; its falling transition starts an access |
| sel_live_n | input | 1 | Active-low primary select, always applied directly |
| sel_lat_n | input | 1 | Active-low secondary select, captured at the falling transition and applied directly while the strobe is high |
| wr_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W (8) | Word address |
| din | input | DATA_W (4) | Write data |
| dout | output | DATA_W (4) | Read data |
| dout_oe | output | 1 | Output drive enable; 0 stands for high impedance |
| dout_valid | output | 1 | Output enabled and carrying access data |

## Verification
The bench builds the block with its default parameters: 8 address bits and 4-bit words, which gives 256 locations. At this size the bench can load every location with random data before the random reads, so each read compares against a known word. It also covers both edges of the address range and re-randomizes the address and the secondary select in every phase of each access. Directed accesses with the secondary select captured high, and writes whose address moves after capture, reach the cases where a wrong latch would corrupt a neighbouring location.

// File: rtl/strobe_sram_pkg.sv
// Package: shared types for the strobe-addressed memory.
// Assumes: nothing beyond IEEE 1800-2017.
package strobe_sram_pkg;

    // Strobe phase as sampled on the previous clock.
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

endpackage

// File: rtl/strobe_capture.sv
// Module: strobe_capture
// Tracks the strobe phase and detects its transitions. Captures the address
// and the secondary select on the falling transition.
// Assumes: strobe_n is synchronous to clk.
module strobe_capture
    import strobe_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              sel_lat_n,
    input  logic [ADDR_W-1:0] addr,
    output phase_e            phase,
    output logic              fall,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_sel_n
);

    // Transition detect against the previously sampled phase.
    assign fall = (phase == PH_HIGH) && !strobe_n;

    // Phase register plus capture of the address and secondary select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_HIGH;
            cap_addr  <= '0;
            cap_sel_n <= 1'b1;
        end else begin
            phase <= strobe_n ? PH_HIGH : PH_LOW;
            if (fall) begin
                cap_addr  <= addr;
                cap_sel_n <= sel_lat_n;
            end
        end
    end

    AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> cap_addr == $past(addr)); // R1
    AST_CAPTURE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> cap_sel_n == $past(sel_lat_n)); // R1
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |=> $stable(cap_addr) && $stable(cap_sel_n)); // R2

endmodule

// File: rtl/strobe_mem_array.sv
// Module: strobe_mem_array
// Word-wide storage with one synchronous write port and one combinational
// read port.
// Assumes: contents are undefined until written; there is no reset.
module strobe_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store one word per enabled clock.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Asynchronous read of the addressed word.
    assign rdata = cells[raddr];

endmodule

// File: rtl/strobe_out_stage.sv
// Module: strobe_out_stage
// Holds the output data register and the access-complete flag, and derives
// the output enable from the phase and the selects.
// Assumes: rd_go is only ever asserted in the low phase.
module strobe_out_stage
    import strobe_sram_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              fall,
    input  logic              rd_go,
    input  logic              sel_live_n,
    input  logic              sel_lat_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              dout_valid
);

    logic ready;

    // Load data during a read; frozen while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            ready <= 1'b0;
        end else if (fall) begin
            ready <= 1'b0;
        end else if (rd_go) begin
            dout  <= mem_rdata;
            ready <= 1'b1;
        end
    end

    // Enable: captured gating while low, live gating while high.
    always_comb begin
        if (phase == PH_LOW) begin
            dout_oe = rd_go;
        end else begin
            dout_oe = !sel_live_n && !sel_lat_n;
        end
    end

    assign dout_valid = dout_oe && ready;

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH) |=> $stable(dout)); // R4
    AST_FIRST_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW && $past(phase) == PH_HIGH) |-> !dout_valid); // R7
    AST_HIGH_LIVE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH && sel_lat_n) |-> !dout_oe); // R5

endmodule

// File: rtl/strobe_sram.sv
// Module: strobe_sram (top)
// Static memory with a strobe-addressed interface: falling-edge capture,
// one-clock access, output hold while the strobe is high.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module strobe_sram
    import strobe_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              sel_live_n,
    input  logic              sel_lat_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              dout_valid
);

    phase_e            phase;
    logic              fall;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_sel_n;
    logic              low_sel;
    logic              rd_go;
    logic              wr_go;
    logic [DATA_W-1:0] mem_rdata;

    strobe_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (strobe_n),
        .sel_lat_n (sel_lat_n),
        .addr      (addr),
        .phase     (phase),
        .fall      (fall),
        .cap_addr  (cap_addr),
        .cap_sel_n (cap_sel_n)
    );

    // Access qualification from the captured select and the live select.
    assign low_sel = (phase == PH_LOW) && !sel_live_n && !cap_sel_n;
    assign rd_go   = low_sel && wr_n;
    assign wr_go   = low_sel && !wr_n;

    strobe_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (wr_go),
        .waddr (cap_addr),
        .wdata (din),
        .raddr (cap_addr),
        .rdata (mem_rdata)
    );

    strobe_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .fall       (fall),
        .rd_go      (rd_go),
        .sel_live_n (sel_live_n),
        .sel_lat_n  (sel_lat_n),
        .mem_rdata  (mem_rdata),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .dout_valid (dout_valid)
    );

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !dout_oe); // R9
    AST_PRIMARY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        sel_live_n |-> !dout_oe); // R6
    AST_DESELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW && cap_sel_n) |-> !dout_oe); // R8

endmodule

// File: tb/test_strobe_sram.sv
`timescale 1ns/1ps
module test_strobe_sram;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe_n = 1'b1;
    logic              sel_live_n = 1'b1;
    logic              sel_lat_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_oe;
    logic              dout_valid;

    logic [DATA_W-1:0] model [DEPTH];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    strobe_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_strobe_sram (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .sel_live_n(sel_live_n),
        .sel_lat_n(sel_lat_n), .wr_n(wr_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid)
    );

    function automatic logic [ADDR_W-1:0] rnd_addr();
        return ADDR_W'($urandom);
    endfunction

    function automatic logic [DATA_W-1:0] rnd_data();
        return DATA_W'($urandom);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Read access with the captured address moved around in every phase.
    task automatic do_read(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] exp;
        exp = model[a];
        @(negedge clk);
        addr = a; sel_lat_n = 1'b0; sel_live_n = 1'b0; wr_n = 1'b1; strobe_n = 1'b0;
        @(negedge clk);
        check(dout_oe == 1'b1, "R3", dout_oe, 1);
        check(dout_valid == 1'b0, "R7", dout_valid, 0);
        addr = rnd_addr(); sel_lat_n = 1'($urandom);
        @(negedge clk);
        check(dout_valid == 1'b1 && dout == exp, "R3", dout, exp);
        addr = rnd_addr(); sel_lat_n = 1'($urandom);
        @(negedge clk);
        check(dout_valid == 1'b1 && dout == exp, "R2", dout, exp);
        strobe_n = 1'b1; sel_lat_n = 1'b0; addr = rnd_addr();
        @(negedge clk);
        check(dout_valid == 1'b1 && dout == exp, "R4", dout, exp);
        sel_lat_n = 1'b1; wr_n = 1'($urandom); addr = rnd_addr();
        @(negedge clk);
        check(dout_oe == 1'b0, "R5", dout_oe, 0);
        sel_lat_n = 1'b0; sel_live_n = 1'b1;
        @(negedge clk);
        check(dout_oe == 1'b0, "R6", dout_oe, 0);
        sel_live_n = 1'b0;
        @(negedge clk);
        check(dout_valid == 1'b1 && dout == exp, "R4", dout, exp);
        sel_live_n = 1'b1; sel_lat_n = 1'b1; wr_n = 1'b1;
    endtask

    // Write access; the address moves after capture.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic s2);
        @(negedge clk);
        addr = a; sel_lat_n = s2; sel_live_n = 1'b0; wr_n = 1'b1; strobe_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b0; din = d; addr = rnd_addr(); sel_lat_n = 1'($urandom);
        @(negedge clk);
        check(dout_oe == 1'b0, s2 ? "R8" : "R9", dout_oe, 0);
        wr_n = 1'b1; strobe_n = 1'b1; sel_live_n = 1'b1; sel_lat_n = 1'b1;
        @(negedge clk);
        if (!s2) model[a] = d;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        repeat (4) @(negedge clk);
        check(dout_valid == 1'b0, "R10", dout_valid, 0);
        check(dout_oe == 1'b0, "R10", dout_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_oe == 1'b0 && dout_valid == 1'b0, "R10", dout_oe, 0);

        // R9: load every location.
        for (int i = 0; i < DEPTH; i++) do_write(ADDR_W'(i), rnd_data(), 1'b0);

        // Directed boundary reads.
        do_read('0);
        do_read('1);

        // R8: write with the secondary select captured high leaves memory alone.
        do_write(8'h00, ~model[8'h00], 1'b1);
        do_write(8'hff, ~model[8'hff], 1'b1);
        do_read(8'h00);
        do_read(8'hff);

        // R1/R8: captured-high select keeps the output off even if live goes low.
        @(negedge clk);
        addr = 8'h10; sel_lat_n = 1'b1; sel_live_n = 1'b0; wr_n = 1'b1; strobe_n = 1'b0;
        @(negedge clk);
        sel_lat_n = 1'b0;
        check(dout_oe == 1'b0, "R1", dout_oe, 0);
        @(negedge clk);
        check(dout_oe == 1'b0, "R8", dout_oe, 0);
        strobe_n = 1'b1; sel_live_n = 1'b1; sel_lat_n = 1'b1;
        @(negedge clk);

        // Random mix of reads and writes.
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(3) == 0) do_write(rnd_addr(), rnd_data(), 1'($urandom));
            else do_read(rnd_addr());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule